// File: doc/BRIEF.md
# RTC Countdown Divider and Update Sequencer

This block is the timekeeping front end of a real-time clock. A one-cycle `tick_i` pulse, arriving at a 32.768 kHz rate in the system clock domain, advances a 15-stage binary divider. A 3-bit oscillator control field picks one of three modes: stopped, where ticks are ignored and the divider holds its value; held, where the divider is pinned at its half-way point; or running, where it counts. When the divider wraps, a one-second update strobe goes to the calendar logic. An update-done pulse follows one cycle later.

A 4-bit rate code selects one divider stage through a 16-way multiplexer. That stage drives the square-wave pin when it is enabled, and its rising edge drives a one-cycle periodic pulse. An update-in-progress flag warns software eight ticks (about 244 µs) before each transfer. The set control removes that flag and suppresses transfers while software rewrites the time.

Top module: `rtc_divider_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sq_out_o`, `periodic_o`, `uip_o`, `update_o` and `update_done_o` are all low.
- R2: For any oscillator field other than 010 and 11x, ticks are ignored and the divider holds its value, so no periodic pulse and no square-wave edge occur.
- R3: With the oscillator field at 110 or 111, the divider is held at its half-way value 2^14. No periodic pulse, UIP or update strobe occurs.
- R4: After the field changes from 11x to 010, the first `update_o` pulse appears exactly 16384 ticks later (half a second).
- R5: In steady running, successive `update_o` pulses are 32768 ticks apart.
- R6: `uip_o` is high for exactly the 8 tick intervals that precede each update transfer, and it is low at all other times. Every `update_o` pulse is preceded by a cycle with `uip_o` high.
- R7: While `set_i` is 1, `uip_o` is low and no `update_o` or `update_done_o` pulse is produced.
- R8: `update_done_o` is a one-cycle pulse that appears in the cycle after each `update_o` pulse.
- R9: Rate code 0 disables the mux output. Code 1 gives a period of 128 ticks, code 2 a period of 256 ticks, and each code c from 3 to 15 gives a period of 2^(c-1) ticks. The range therefore runs from 4 ticks (122 µs) to 16384 ticks (500 ms).
- R10: `periodic_o` is high for one cycle at each rising edge of the selected stage. With `sqwe_i` = 1, `sq_out_o` follows the selected stage, which is high for half of each period.
- R11: With `sqwe_i` = 0, `sq_out_o` stays low while `periodic_o` keeps firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 32.768 kHz tick enable |
| dv_i | input | 3 | Oscillator/divider control field |
| rs_i | input | 4 | Rate-select code |
| set_i | input | 1 | Update inhibit from software |
| sqwe_i | input | 1 | Square-wave output enable |
| sq_out_o | output | 1 | Square-wave output |
| periodic_o | output | 1 | One-cycle pulse on each rising edge of the selected stage |
| uip_o | output | 1 | Update-in-progress status |
| update_o | output | 1 | One-second update transfer strobe |
| update_done_o | output | 1 | Update-ended pulse |

## Verification
The checker assumes that a rate-code change and a mode change each remain stable for at least two clocks before a quiet output is demanded. It also assumes that `set_i` changes only between clock edges, so an update strobe can be related to the value `set_i` had one cycle earlier. The bench drives every input at the falling edge and keeps the oscillator field constant across each measured window. It measures a periodic interval only after discarding the first pulse that follows a rate change.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    typedef enum logic [1:0] {
        OSC_STOP = 2'd0,
        OSC_HOLD = 2'd1,
        OSC_RUN  = 2'd2
    } osc_mode_e;

    typedef struct packed {
        logic       valid;
        logic [4:0] idx;
    } tap_sel_t;

    localparam int RS_W       = 4;
    localparam int RATE_CODES = 1 << RS_W;

    // Only 010 keeps time; 11x parks the chain; all else stops it.
    function automatic osc_mode_e decode_dv(input logic [2:0] dv);
        osc_mode_e m;
        if (dv == 3'b010)        m = OSC_RUN;
        else if (dv[2:1] == 2'b11) m = OSC_HOLD;
        else                     m = OSC_STOP;
        return m;
    endfunction

    // Divider stage driven by each rate code (period = 2^(idx+1) ticks).
    function automatic tap_sel_t rate_tap(input logic [RS_W-1:0] rs);
        tap_sel_t t;
        t.valid = (rs != '0);
        if (rs == 4'd1 || rs == 4'd2) t.idx = 5'(rs) + 5'd5;
        else if (rs == 4'd0)          t.idx = 5'd0;
        else                          t.idx = 5'(rs) - 5'd2;
        return t;
    endfunction

endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
    import rtc_div_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  osc_mode_e        mode_i,
    output logic [DIV_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [DIV_W-1:0] CNT_MAX  = '1;
    localparam logic [DIV_W-1:0] CNT_HALF = DIV_W'(1) << (DIV_W - 1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (mode_i)
                OSC_HOLD: cnt_q <= CNT_HALF;
                OSC_RUN:  if (tick_i) cnt_q <= cnt_q + 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (mode_i == OSC_RUN) && (cnt_q == CNT_MAX);
endmodule

// File: rtl/rtc_rate_mux.sv
module rtc_rate_mux
    import rtc_div_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cnt_i,
    input  logic [RS_W-1:0]  rs_i,
    input  logic             sqwe_i,
    output logic             sq_o,
    output logic             pulse_o
);
    logic [RATE_CODES-1:0] cand;
    logic                  tap_now;
    logic                  tap_d;

    for (genvar c = 0; c < RATE_CODES; c++) begin : g_tap
        localparam tap_sel_t TS = rate_tap(RS_W'(c));
        if (TS.valid && (int'(TS.idx) < DIV_W)) begin : g_on
            assign cand[c] = cnt_i[TS.idx];
        end else begin : g_off
            assign cand[c] = 1'b0;
        end
    end

    assign tap_now = cand[rs_i];

    always_ff @(posedge clk) begin
        if (rst) tap_d <= 1'b0;
        else     tap_d <= tap_now;
    end

    assign pulse_o = tap_now && !tap_d;
    assign sq_o    = sqwe_i && tap_now;
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_div_pkg::*;
#(
    parameter int DIV_W      = 15,
    parameter int LEAD_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cnt_i,
    input  osc_mode_e        mode_i,
    input  logic             set_i,
    input  logic             wrap_i,
    output logic             uip_o,
    output logic             stb_o,
    output logic             done_o
);
    localparam logic [DIV_W-1:0] WIN_LO = {DIV_W{1'b1}} - DIV_W'(LEAD_TICKS - 1);

    logic stb_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            stb_q  <= wrap_i && !set_i;
            done_q <= stb_q;
        end
    end

    assign uip_o  = (mode_i == OSC_RUN) && !set_i && (cnt_i >= WIN_LO);
    assign stb_o  = stb_q;
    assign done_o = done_q;
endmodule

// File: rtl/rtc_divider_top.sv
module rtc_divider_top
    import rtc_div_pkg::*;
#(
    parameter int DIV_W      = 15,
    parameter int LEAD_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic [2:0] dv_i,
    input  logic [3:0] rs_i,
    input  logic       set_i,
    input  logic       sqwe_i,
    output logic       sq_out_o,
    output logic       periodic_o,
    output logic       uip_o,
    output logic       update_o,
    output logic       update_done_o
);
    osc_mode_e        mode;
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign mode = decode_dv(dv_i);

    rtc_div_chain #(.DIV_W(DIV_W)) u_chain (
        .clk(clk), .rst(rst), .tick_i(tick_i), .mode_i(mode),
        .cnt_o(cnt), .wrap_o(wrap)
    );

    rtc_rate_mux #(.DIV_W(DIV_W)) u_mux (
        .clk(clk), .rst(rst), .cnt_i(cnt), .rs_i(rs_i), .sqwe_i(sqwe_i),
        .sq_o(sq_out_o), .pulse_o(periodic_o)
    );

    rtc_update_seq #(.DIV_W(DIV_W), .LEAD_TICKS(LEAD_TICKS)) u_seq (
        .clk(clk), .rst(rst), .cnt_i(cnt), .mode_i(mode), .set_i(set_i),
        .wrap_i(wrap), .uip_o(uip_o), .stb_o(update_o), .done_o(update_done_o)
    );
endmodule

// File: rtl/rtc_divider_chk.sv
module rtc_divider_chk
    import rtc_div_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic [2:0] dv_i,
    input logic [3:0] rs_i,
    input logic       set_i,
    input logic       sqwe_i,
    input logic       sq_out_o,
    input logic       periodic_o,
    input logic       uip_o,
    input logic       update_o,
    input logic       update_done_o
);
    logic is_stop, is_hold;
    assign is_stop = (decode_dv(dv_i) == OSC_STOP);
    assign is_hold = (decode_dv(dv_i) == OSC_HOLD);

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !update_o && !update_done_o);

    a_r2_stop_no_pulse: assert property (@(posedge clk) disable iff (rst)
        $past(is_stop) && $past(is_stop, 2) && $stable(rs_i) |-> !periodic_o);

    a_r3_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        is_hold && $past(is_hold) && $past(is_hold, 2) && $stable(rs_i)
        |-> !periodic_o && !uip_o);

    a_r6_uip_before_update: assert property (@(posedge clk) disable iff (rst)
        update_o |-> $past(uip_o));

    a_r7_set_blocks_uip: assert property (@(posedge clk) disable iff (rst)
        set_i |-> !uip_o);

    a_r7_set_blocks_update: assert property (@(posedge clk) disable iff (rst)
        update_o |-> !$past(set_i));

    a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
        update_done_o |-> $past(update_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        update_o |=> update_done_o && !update_o);

    a_r11_sq_off: assert property (@(posedge clk) disable iff (rst)
        !sqwe_i |-> !sq_out_o);
endmodule

bind rtc_divider_top rtc_divider_chk u_chk (.*);

// File: tb/sim_rtc_divider_top.sv
module sim_rtc_divider_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b0;
    logic [2:0] dv_i = 3'b000;
    logic [3:0] rs_i = 4'd0;
    logic set_i = 1'b0;
    logic sqwe_i = 1'b0;
    logic sq_out_o, periodic_o, uip_o, update_o, update_done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    rtc_divider_top u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .dv_i(dv_i), .rs_i(rs_i),
        .set_i(set_i), .sqwe_i(sqwe_i), .sq_out_o(sq_out_o),
        .periodic_o(periodic_o), .uip_o(uip_o), .update_o(update_o),
        .update_done_o(update_done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count posedges until update_o is seen; also count cycles with uip high.
    task automatic wait_update(output int n, output int uips);
        n = 0; uips = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
            if (uip_o) uips++;
        end while (!update_o && n < 40000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!sq_out_o && !periodic_o && !uip_o && !update_o && !update_done_o,
            "R1 outputs during reset", 1, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!update_o && !update_done_o && !uip_o, "R1 first cycle after reset", 1, 0);
    endtask

    task automatic t_stop();
        int p = 0, s = 0;
        dv_i = 3'b101; rs_i = 4'd3; sqwe_i = 1'b1; tick_i = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (periodic_o) p++;
            if (sq_out_o) s++;
        end
        chk(p == 0, "R2 stop mode periodic pulses", p, 0);
        chk(s == 0, "R2 stop mode square wave", s, 0);
    endtask

    task automatic t_hold();
        int p = 0, u = 0, up = 0;
        dv_i = 3'b111;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (periodic_o) p++;
            if (uip_o) u++;
            if (update_o) up++;
        end
        chk(p == 0, "R3 hold periodic pulses", p, 0);
        chk(u == 0, "R3 hold uip", u, 0);
        chk(up == 0, "R3 hold updates", up, 0);
    endtask

    task automatic t_first_and_second();
        int n, uips;
        dv_i = 3'b010;
        wait_update(n, uips);
        chk(n == 16384, "R4 first update delay", n, 16384);
        chk(uips == 8, "R6 uip window before first update", uips, 8);
        @(negedge clk);
        chk(update_done_o && !update_o, "R8 done one cycle after update", update_done_o, 1);
        // One posedge already consumed by the done check above.
        wait_update(n, uips);
        chk(n == 32767, "R5 second update spacing", n + 1, 32768);
        chk(uips == 8, "R6 uip window before second update", uips, 8);
        @(negedge clk);
        chk(update_done_o, "R8 done after second update", update_done_o, 1);
    endtask

    task automatic wait_pulse();
        int g = 0;
        do begin @(negedge clk); g++; end while (!periodic_o && g < 20000);
    endtask

    task automatic t_rate(input logic [3:0] code, input int period, input string req);
        int n = 0, h = 0;
        rs_i = code; sqwe_i = 1'b1;
        wait_pulse();
        wait_pulse();
        do begin
            if (sq_out_o) h++;
            @(negedge clk); n++;
        end while (!periodic_o && n < 20000);
        chk(n == period, req, n, period);
        chk(h == period / 2, "R10 square wave high half period", h, period / 2);
    endtask

    task automatic t_rate_off();
        int p = 0, s = 0;
        rs_i = 4'd0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (periodic_o) p++;
            if (sq_out_o) s++;
        end
        chk(p == 0, "R9 code 0 disables pulses", p, 0);
        chk(s == 0, "R9 code 0 square wave low", s, 0);
    endtask

    task automatic t_sqwe_off();
        int p = 0, s = 0;
        rs_i = 4'd3; sqwe_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (periodic_o) p++;
            if (sq_out_o) s++;
        end
        chk(s == 0, "R11 square wave held low", s, 0);
        chk(p == 10, "R11 pulses continue", p, 10);
    endtask

    task automatic t_set();
        int g = 0, up = 0, dn = 0, u = 0;
        do begin @(negedge clk); g++; end while (!uip_o && g < 40000);
        chk(uip_o, "R6 uip reached", uip_o, 1);
        set_i = 1'b1;
        #1;
        chk(!uip_o, "R7 set clears uip", uip_o, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (update_o) up++;
            if (update_done_o) dn++;
            if (uip_o) u++;
        end
        chk(up == 0, "R7 set suppresses update", up, 0);
        chk(dn == 0, "R7 set suppresses done", dn, 0);
        chk(u == 0, "R7 uip stays low under set", u, 0);
        set_i = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_stop();
        t_hold();
        t_first_and_second();
        t_rate(4'd3, 4, "R9 code 3 period");
        t_rate(4'd1, 128, "R9 code 1 period");
        t_rate(4'd2, 256, "R9 code 2 period");
        t_rate(4'd14, 8192, "R9 code 14 period");
        t_rate_off();
        t_sqwe_off();
        t_set();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule